// File: doc/BRIEF.md
# Signed-Amount Bidirectional Integer Shifter

This block shifts a 32-bit or 64-bit integer held in a 64-bit register value. The shift amount is signed, and its sign picks the direction. A positive amount shifts left. A negative amount shifts right arithmetically by its magnitude. The amount comes from one of two places. It is either a 7-bit immediate held in two separate fields of the operation word, or a signed 32-bit value supplied by the host.

In 32-bit mode only the lower half of the operand is shifted, and the upper half passes through unchanged. In 64-bit mode the whole operand is shifted. The block takes one operation per cycle. One clock later it presents the destination value together with a one-cycle write strobe. The surrounding pipeline owns the register file and writes it back using that strobe.

Top module: `bidir_shift_unit`

## Requirements
- R1: While reset is asserted, and after it is released with no operation issued, `wr_en` is 0 and `dst_val` is 0.
- R2: The immediate amount is 7-bit two's complement. Its bits 3:0 are `op_word[3:0]`, its bits 6:4 are `op_word[7:5]`, and bit 6 is the sign.
- R3: With an immediate amount, a value of 0 or more shifts left by that value. A negative value shifts right arithmetically (sign-filling) by its magnitude. An amount of 0 returns the operand unchanged.
- R4: `op_word[21:20]` selects the mode: 2'b00 is 32-bit shift and 2'b10 is 64-bit shift. Codes 2'b01 and 2'b11 produce no write, and `dst_val` keeps its previous value.
- R5: In 32-bit mode, `dst_val[31:0]` is the signed shift of `src_val[31:0]` and `dst_val[63:32]` equals `src_val[63:32]`.
- R6: In 64-bit mode, all 64 bits of `src_val` are shifted as one signed integer.
- R7: When `amt_from_host` is 1, `host_amt` is read as a signed 32-bit value. A value greater than 0 shifts left by that value. A value of 0 or less shifts right arithmetically by its negation, and the immediate fields are ignored.
- R8: A shift magnitude at or above the operand width (32 or 64) gives 0 for a left shift and copies of the operand sign bit for a right shift. This includes a host amount of -2^31.
- R9: `wr_en` is 1 in exactly the cycle after an accepted `op_valid` with a legal mode, and 0 otherwise. `dst_val` changes only in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_word | input | 32 | Operation word: mode in bits 21:20, immediate amount in bits 7:5 and 3:0 |
| src_val | input | 64 | Source register value |
| host_amt | input | 32 | Signed shift amount from the host |
| amt_from_host | input | 1 | 1 selects `host_amt`, 0 selects the immediate amount |
| dst_val | output | 64 | Registered destination value |
| wr_en | output | 1 | One-cycle write strobe for `dst_val` |

## Verification
Two functions can act on the same result in one cycle: upper-half pass-through in 32-bit mode and saturation. The case is provoked by issuing 32-bit operations with host amounts far beyond 32, including -2^31, on operands whose upper and lower halves have different sign bits. It is judged by requiring the upper word to equal the source, while the lower word is all zeros or all copies of bit 31.

Write strobe and hold timing also coincide when operations run back to back, interleaved with reserved modes and idle cycles. The scoreboard then expects the strobe and the held value cycle by cycle.

// File: rtl/bshift_pkg.sv
package bshift_pkg;
  typedef enum logic [1:0] {
    MODE_W32  = 2'b00,
    MODE_RSV1 = 2'b01,
    MODE_W64  = 2'b10,
    MODE_RSV3 = 2'b11
  } shmode_e;
endpackage

// File: rtl/bshift_amt.sv
// Turns the immediate or host amount into a direction and a magnitude.
module bshift_amt #(
  parameter int IMM_W  = 7,
  parameter int HOST_W = 32,
  parameter int MAG_W  = HOST_W + 1
) (
  input  logic [IMM_W-1:0]  imm_amt,
  input  logic [HOST_W-1:0] host_amt,
  input  logic              use_host,
  output logic              go_left,
  output logic [MAG_W-1:0]  mag
);
  logic [MAG_W-1:0] imm_ext;
  logic [MAG_W-1:0] host_ext;
  logic [MAG_W-1:0] chosen;

  always_comb begin
    imm_ext  = {{(MAG_W-IMM_W){imm_amt[IMM_W-1]}}, imm_amt};
    host_ext = {{(MAG_W-HOST_W){host_amt[HOST_W-1]}}, host_amt};
    if (use_host) begin
      chosen  = host_ext;
      // host: strictly positive goes left, zero or negative goes right
      go_left = !host_ext[MAG_W-1] && (host_ext != '0);
    end else begin
      chosen  = imm_ext;
      // immediate: zero or positive goes left
      go_left = !imm_ext[MAG_W-1];
    end
    mag = go_left ? chosen : (~chosen + 1'b1);
  end
endmodule

// File: rtl/bshift_core.sv
// Saturating signed shifter of one operand width.
module bshift_core #(
  parameter int W     = 64,
  parameter int MAG_W = 33
) (
  input  logic [W-1:0]     a,
  input  logic             go_left,
  input  logic [MAG_W-1:0] mag,
  output logic [W-1:0]     y
);
  localparam int SH_W = $clog2(W);

  logic [SH_W-1:0] sh;
  logic            too_far;

  always_comb begin
    sh      = mag[SH_W-1:0];
    too_far = (mag >= MAG_W'(W));
    if (go_left) begin
      y = too_far ? '0 : (a << sh);
    end else begin
      y = too_far ? {W{a[W-1]}} : W'($signed(a) >>> sh);
    end
  end
endmodule

// File: rtl/bidir_shift_unit.sv
module bidir_shift_unit
  import bshift_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int OP_W      = 32,
  parameter int HOST_W    = 32,
  parameter int IMM_LO_W  = 4,
  parameter int IMM_HI_LSB = 5,
  parameter int IMM_HI_W  = 3,
  parameter int MODE_LSB  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   op_word,
  input  logic [DATA_W-1:0] src_val,
  input  logic [HOST_W-1:0] host_amt,
  input  logic              amt_from_host,
  output logic [DATA_W-1:0] dst_val,
  output logic              wr_en
);
  localparam int HALF_W = DATA_W / 2;
  localparam int IMM_W  = IMM_LO_W + IMM_HI_W;
  localparam int MAG_W  = HOST_W + 1;

  shmode_e          mode;
  logic [IMM_W-1:0] imm_amt;
  logic             go_left;
  logic [MAG_W-1:0] mag;
  logic [HALF_W-1:0] y_half;
  logic [DATA_W-1:0] y_full;
  logic             legal_nxt;
  logic [DATA_W-1:0] val_nxt;

  assign mode    = shmode_e'(op_word[MODE_LSB +: 2]);
  // immediate reassembled from two separate fields
  assign imm_amt = {op_word[IMM_HI_LSB +: IMM_HI_W], op_word[IMM_LO_W-1:0]};

  bshift_amt #(.IMM_W(IMM_W), .HOST_W(HOST_W), .MAG_W(MAG_W)) u_amt (
    .imm_amt (imm_amt),
    .host_amt(host_amt),
    .use_host(amt_from_host),
    .go_left (go_left),
    .mag     (mag)
  );

  bshift_core #(.W(HALF_W), .MAG_W(MAG_W)) u_core_half (
    .a(src_val[HALF_W-1:0]), .go_left(go_left), .mag(mag), .y(y_half)
  );

  bshift_core #(.W(DATA_W), .MAG_W(MAG_W)) u_core_full (
    .a(src_val), .go_left(go_left), .mag(mag), .y(y_full)
  );

  // next-state
  always_comb begin
    legal_nxt = op_valid && ((mode == MODE_W32) || (mode == MODE_W64));
    if (mode == MODE_W64) begin
      val_nxt = y_full;
    end else begin
      val_nxt = {src_val[DATA_W-1:HALF_W], y_half};
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      dst_val <= '0;
    end else begin
      wr_en <= legal_nxt;
      if (legal_nxt) begin
        dst_val <= val_nxt;
      end
    end
  end

  logic unused_op_bits;
  assign unused_op_bits = ^{op_word};

  a_r5_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_word[MODE_LSB +: 2] == 2'b00
    |=> dst_val[DATA_W-1:HALF_W] == $past(src_val[DATA_W-1:HALF_W]));

  a_r4_reserved_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_word[MODE_LSB] |=> !wr_en && $stable(dst_val));

  a_r9_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !wr_en && $stable(dst_val));

  a_r9_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !op_word[MODE_LSB] |=> wr_en);

  a_r3_zero_amount: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_word[MODE_LSB +: 2] == 2'b10 && !amt_from_host &&
    imm_amt == '0 |=> dst_val == $past(src_val));

  a_r8_host_min_right: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_word[MODE_LSB +: 2] == 2'b10 && amt_from_host &&
    host_amt == {1'b1, {(HOST_W-1){1'b0}}}
    |=> dst_val == {DATA_W{$past(src_val[DATA_W-1])}});
endmodule

// File: tb/bidir_shift_unit_bench.sv
module bidir_shift_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [31:0] op_word;
  logic [63:0] src_val;
  logic [31:0] host_amt;
  logic        amt_from_host;
  logic [63:0] dst_val;
  logic        wr_en;

  typedef struct {
    logic [63:0] val;
    logic        we;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          n_checks;
  int          n_fails;
  logic [63:0] held_val;
  bit          mon_on;

  bidir_shift_unit u_bidir_shift_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_word(op_word),
    .src_val(src_val), .host_amt(host_amt), .amt_from_host(amt_from_host),
    .dst_val(dst_val), .wr_en(wr_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] ref_shift(logic [63:0] s, logic [31:0] op,
                                            logic [31:0] h, bit uh, bit w64);
    longint amt;
    longint m;
    bit     left;
    logic [31:0] lo;
    logic [63:0] r;
    logic [6:0]  imm;
    imm = {op[7:5], op[3:0]};
    if (uh) begin
      amt  = longint'($signed(h));
      left = (amt > 0);
    end else begin
      amt  = longint'($signed(imm));
      left = (amt >= 0);
    end
    m = left ? amt : -amt;
    if (w64) begin
      if (left) r = (m >= 64) ? 64'd0 : (s << m);
      else      r = (m >= 64) ? {64{s[63]}} : 64'($signed(s) >>> m);
    end else begin
      if (left) lo = (m >= 32) ? 32'd0 : (s[31:0] << m);
      else      lo = (m >= 32) ? {32{s[31]}} : 32'($signed(s[31:0]) >>> m);
      r = {s[63:32], lo};
    end
    return r;
  endfunction

  function automatic logic [31:0] mk_op(logic [1:0] md, logic [6:0] imm);
    return {10'h155, md, 12'hA5A, imm[6:4], 1'b1, imm[3:0]};
  endfunction

  task automatic drive(bit v, logic [31:0] op, logic [63:0] s,
                       logic [31:0] h, bit uh, string tag);
    exp_t e;
    @(negedge clk);
    op_valid = v; op_word = op; src_val = s; host_amt = h; amt_from_host = uh;
    if (v && !op[20]) begin
      held_val = ref_shift(s, op, h, uh, op[21]);
      e.we = 1'b1;
    end else begin
      e.we = 1'b0;
    end
    e.val = held_val;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  always begin
    @(posedge clk);
    #1;
    if (mon_on && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_checks++;
      if (wr_en !== e.we || dst_val !== e.val) begin
        n_fails++;
        $display("FAIL %s: we=%0b val=%h expected we=%0b val=%h",
                 e.tag, wr_en, dst_val, e.we, e.val);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_fails++;
    n_checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    n_checks = 0; n_fails = 0; held_val = 64'd0; mon_on = 1'b0;
    rst_n = 1'b0; op_valid = 1'b0; op_word = '0; src_val = '0;
    host_amt = '0; amt_from_host = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    n_checks++;
    if (wr_en !== 1'b0 || dst_val !== 64'd0) begin
      n_fails++;
      $display("FAIL R1: we=%0b val=%h expected we=0 val=0", wr_en, dst_val);
    end
    @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;
    drive(1'b0, '0, '0, '0, 1'b0, "R1 idle after reset");

    // R2/R3 immediate, 64-bit
    drive(1'b1, mk_op(2'b10, 7'd0),   64'h8123_4567_89AB_CDEF, 0, 1'b0, "R3 zero amount");
    drive(1'b1, mk_op(2'b10, 7'd4),   64'h0000_0000_0000_00F1, 0, 1'b0, "R2 R6 left 4");
    drive(1'b1, mk_op(2'b10, 7'd20),  64'h0000_0000_0000_0001, 0, 1'b0, "R2 upper field left 20");
    drive(1'b1, mk_op(2'b10, 7'h7F),  64'h8000_0000_0000_0000, 0, 1'b0, "R3 right 1 sign fill");
    drive(1'b1, mk_op(2'b10, 7'h40),  64'h7FFF_0000_0000_0000, 0, 1'b0, "R3 right 64 positive");
    drive(1'b1, mk_op(2'b10, 7'd63),  64'h0000_0000_0000_0003, 0, 1'b0, "R6 left 63");
    drive(1'b1, mk_op(2'b10, 7'h50),  64'hF000_0000_0000_0000, 0, 1'b0, "R8 right 48");
    // R5 32-bit
    drive(1'b1, mk_op(2'b00, 7'd8),   64'hDEAD_BEEF_0000_00AB, 0, 1'b0, "R5 left 8 upper kept");
    drive(1'b1, mk_op(2'b00, 7'h7C),  64'h1234_5678_8000_0010, 0, 1'b0, "R5 right 4 low sign");
    drive(1'b1, mk_op(2'b00, 7'd40),  64'hFFFF_FFFF_0000_0001, 0, 1'b0, "R8 R5 left 40");
    drive(1'b1, mk_op(2'b00, 7'h40),  64'h0000_0001_8000_0000, 0, 1'b0, "R8 R5 right 64");
    // R4 reserved modes, R9 hold
    drive(1'b1, mk_op(2'b01, 7'd1),   64'h1111_2222_3333_4444, 0, 1'b0, "R4 mode 01 no write");
    drive(1'b1, mk_op(2'b11, 7'd1),   64'h1111_2222_3333_4444, 0, 1'b0, "R4 mode 11 no write");
    drive(1'b0, mk_op(2'b10, 7'd1),   64'h5555_5555_5555_5555, 0, 1'b0, "R9 idle holds");
    // R7 host amounts
    drive(1'b1, mk_op(2'b10, 7'd5),   64'h0000_0000_0000_0001, 32'd3, 1'b1, "R7 host left 3");
    drive(1'b1, mk_op(2'b10, 7'd5),   64'h8000_0000_0000_0000, 32'hFFFF_FFFE, 1'b1, "R7 host right 2");
    drive(1'b1, mk_op(2'b10, 7'd5),   64'h8000_0000_0000_0001, 32'd0, 1'b1, "R7 host zero");
    drive(1'b1, mk_op(2'b10, 7'd5),   64'h8000_0000_0000_0001, 32'h8000_0000, 1'b1, "R8 R7 host min");
    drive(1'b1, mk_op(2'b00, 7'd5),   64'hABCD_0000_8000_0000, 32'h8000_0000, 1'b1, "R8 R5 host min 32");
    drive(1'b1, mk_op(2'b00, 7'd5),   64'h0123_4567_7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, "R8 R5 host max 32");
    drive(1'b1, mk_op(2'b10, 7'd5),   64'hFFFF_FFFF_FFFF_FFFF, 32'd64, 1'b1, "R8 host left 64");

    for (int i = 0; i < 300; i++) begin
      logic [1:0] md;
      logic [6:0] im;
      logic [31:0] h;
      md = 2'($urandom_range(0, 3));
      im = 7'($urandom);
      h  = ($urandom_range(0, 3) == 0) ? $urandom : 32'($signed($urandom_range(0, 140)) - 70);
      drive($urandom_range(0, 4) != 0, mk_op(md, im),
            {$urandom, $urandom}, h, 1'($urandom), "R9 R7 R5 R6 mixed");
    end
    drive(1'b0, '0, '0, '0, 1'b0, "R9 tail idle");
    @(negedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule